// File: doc/BRIEF.md
# Return address prediction stack

This block keeps a short hardware stack of return addresses for an in-order pipeline that uses RISC-V style register conventions. It sees each decoded jump. A jump that writes the link register `ra` (register 1) is treated as a call, and the address of the instruction after it is stored. A register-indirect jump that reads `ra` is treated as a return, and the most recent stored address is offered as the predicted next PC. The stack does not check whether the prediction turns out to be right, and it does not repair itself after a wrong guess.

The prediction is combinational from the decoded fields and the current stack contents, so fetch can redirect in the same cycle the return is decoded. The stack state updates on the rising clock edge. Storage is a circular buffer of `DEPTH` entries. When calls nest deeper than that, the newest addresses are kept and the oldest are lost, so only the outermost returns predict wrongly.

Top module: `ras_predictor`

## Requirements
- R1: When `instr_valid`=1, `jmp_kind` is 2'b01 (direct jump) or 2'b10 (register jump), and `rd_idx`=1, the value `pc`+4 (modulo 2^XLEN) is pushed. A later return with no other stack operation in between predicts exactly that value.
- R2: When `instr_valid`=1, `jmp_kind`=2'b10 and `rs1_idx`=1, `ret_hit` is 1 in that same cycle. If the stack is not empty, `pred_valid` is 1, `pred_pc` equals the newest entry, and that entry is removed.
- R3: A return on an empty stack gives `ret_hit`=1, `pred_valid`=0 and `pred_pc`=0, and leaves the stack empty.
- R4: After more than `DEPTH` pushes without pops, the stack holds the newest `DEPTH` addresses. `DEPTH` successive returns yield them newest first, and the return after those finds the stack empty.
- R5: A register jump with both `rd_idx`=1 and `rs1_idx`=1 predicts from the old newest entry. That entry is then replaced by `pc`+4, so the entry count is unchanged. If the stack was empty, the count becomes one.
- R6: An instruction that is neither a call nor a return leaves the stack unchanged and gives `ret_hit`=0. This covers `instr_valid`=0, `jmp_kind` 2'b00 or 2'b11, a direct jump whose `rd_idx` is not 1 (its `rs1_idx` is ignored), and a register jump with `rd_idx` and `rs1_idx` both other than 1.
- R7: A synchronous reset (`rst`=1 at a rising edge) empties the stack.
- R8: `pred_valid` is 1 only while `ret_hit` is 1, and `pred_pc` is 0 whenever `pred_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | A decoded instruction is present this cycle |
| jmp_kind | input | 2 | 00 none, 01 direct jump, 10 register jump, 11 none |
| rd_idx | input | REG_W | Destination register number |
| rs1_idx | input | REG_W | Source register number of a register jump |
| pc | input | XLEN | Address of the decoded instruction |
| ret_hit | output | 1 | The instruction is recognised as a return |
| pred_valid | output | 1 | `pred_pc` holds a usable prediction |
| pred_pc | output | XLEN | Predicted return target, 0 when not valid |

## Verification
The bench builds the block with `DEPTH`=4 and `XLEN`=16. With only four entries, overflow and wrap of the circular pointer happen after a few calls. This lets a full sweep over every combination of destination register, source register and jump kind pass through the full, wrapped and empty states many times. That sweep is checked against an arithmetic model. Directed sequences pin down the overflow order, the combined pop-and-push, the ignored encodings and a reset taken while entries are held.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        JK_NONE = 2'b00,
        JK_JAL  = 2'b01,
        JK_JALR = 2'b10,
        JK_RSVD = 2'b11
    } jump_kind_e;

    typedef struct packed {
        logic push;
        logic pop;
    } stack_op_t;

endpackage

// File: rtl/ras_decode.sv
module ras_decode
    import ras_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int RA_IDX = 1
) (
    input  logic             instr_valid,
    input  logic [1:0]       jmp_kind,
    input  logic [REG_W-1:0] rd_idx,
    input  logic [REG_W-1:0] rs1_idx,
    output stack_op_t        op
);

    localparam logic [REG_W-1:0] LINK_REG = REG_W'(RA_IDX);

    jump_kind_e kind;
    logic       links;

    always_comb begin
        kind    = jump_kind_e'(jmp_kind);
        links   = (kind == JK_JAL) || (kind == JK_JALR);
        op.push = instr_valid && links && (rd_idx == LINK_REG);
        op.pop  = instr_valid && (kind == JK_JALR) && (rs1_idx == LINK_REG);
    end

endmodule

// File: rtl/ras_stack.sv
module ras_stack
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  stack_op_t       op,
    input  logic [XLEN-1:0] push_val,
    output logic            top_valid,
    output logic [XLEN-1:0] top_val
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][XLEN-1:0] slot;
        logic [PTR_W-1:0]           ptr;
        logic [CNT_W-1:0]           cnt;
    } stk_t;

    stk_t st_d, st_q;
    logic [PTR_W-1:0] top_idx;
    logic             has_entry;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST_IDX : p - PTR_W'(1);
    endfunction

    always_comb begin
        top_idx   = ptr_dec(st_q.ptr);
        has_entry = (st_q.cnt != '0);
        top_valid = has_entry;
        top_val   = st_q.slot[top_idx];

        st_d = st_q;
        if (op.pop && op.push && has_entry) begin
            st_d.slot[top_idx] = push_val;
        end else begin
            if (op.pop && has_entry) begin
                st_d.ptr = top_idx;
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
            if (op.push) begin
                st_d.slot[st_q.ptr] = push_val;
                st_d.ptr = ptr_inc(st_q.ptr);
                st_d.cnt = (st_q.cnt == FULL_CNT) ? st_q.cnt : st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
    import ras_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int XLEN   = 32,
    parameter int REG_W  = 5,
    parameter int RA_IDX = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid,
    input  logic [1:0]       jmp_kind,
    input  logic [REG_W-1:0] rd_idx,
    input  logic [REG_W-1:0] rs1_idx,
    input  logic [XLEN-1:0]  pc,
    output logic             ret_hit,
    output logic             pred_valid,
    output logic [XLEN-1:0]  pred_pc
);

    stack_op_t       op;
    logic            top_valid;
    logic [XLEN-1:0] top_val;
    logic [XLEN-1:0] link_addr;

    ras_decode #(
        .REG_W  (REG_W),
        .RA_IDX (RA_IDX)
    ) u_decode (
        .instr_valid (instr_valid),
        .jmp_kind    (jmp_kind),
        .rd_idx      (rd_idx),
        .rs1_idx     (rs1_idx),
        .op          (op)
    );

    ras_stack #(
        .DEPTH (DEPTH),
        .XLEN  (XLEN)
    ) u_stack (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .push_val  (link_addr),
        .top_valid (top_valid),
        .top_val   (top_val)
    );

    always_comb begin
        link_addr  = pc + XLEN'(4);
        ret_hit    = op.pop;
        pred_valid = op.pop && top_valid;
        pred_pc    = pred_valid ? top_val : '0;
    end

endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
    parameter int XLEN   = 32,
    parameter int REG_W  = 5,
    parameter int RA_IDX = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             instr_valid,
    input logic [1:0]       jmp_kind,
    input logic [REG_W-1:0] rd_idx,
    input logic [REG_W-1:0] rs1_idx,
    input logic [XLEN-1:0]  pc,
    input logic             ret_hit,
    input logic             pred_valid,
    input logic [XLEN-1:0]  pred_pc
);

    logic is_call, is_ret;
    assign is_call = instr_valid && (jmp_kind == 2'b01 || jmp_kind == 2'b10)
                     && (rd_idx == REG_W'(RA_IDX));
    assign is_ret  = instr_valid && (jmp_kind == 2'b10) && (rs1_idx == REG_W'(RA_IDX));

    AST_PUSH_PREDICTED: assert property (@(posedge clk) disable iff (rst)
        (is_call && !is_ret) ##1 is_ret |-> pred_valid && pred_pc == $past(pc) + XLEN'(4)); // R1
    AST_RET_ONLY_ON_JALR_RA: assert property (@(posedge clk) disable iff (rst)
        ret_hit |-> is_ret); // R2
    AST_SWAP_PREDICTED: assert property (@(posedge clk) disable iff (rst)
        (is_call && is_ret) ##1 is_ret |-> pred_valid && pred_pc == $past(pc) + XLEN'(4)); // R5
    AST_NON_RET_SILENT: assert property (@(posedge clk) disable iff (rst)
        !is_ret |-> !ret_hit); // R6
    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) && is_ret |-> !pred_valid); // R7
    AST_VALID_NEEDS_RET: assert property (@(posedge clk) disable iff (rst)
        pred_valid |-> ret_hit); // R8
    AST_PC_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pred_valid |-> pred_pc == '0); // R8

endmodule

bind ras_predictor ras_checker #(
    .XLEN   (XLEN),
    .REG_W  (REG_W),
    .RA_IDX (RA_IDX)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .jmp_kind    (jmp_kind),
    .rd_idx      (rd_idx),
    .rs1_idx     (rs1_idx),
    .pc          (pc),
    .ret_hit     (ret_hit),
    .pred_valid  (pred_valid),
    .pred_pc     (pred_pc)
);

// File: tb/sim_ras_predictor.sv
`timescale 1ns/1ps
module sim_ras_predictor;

    localparam int D = 4;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         instr_valid = 1'b0;
    logic [1:0]   jmp_kind = 2'b00;
    logic [4:0]   rd_idx = '0;
    logic [4:0]   rs1_idx = '0;
    logic [W-1:0] pc = '0;
    logic         ret_hit, pred_valid;
    logic [W-1:0] pred_pc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0] m_slot [D];
    int m_ptr = 0;
    int m_cnt = 0;
    logic         g_rh, g_pv;
    logic [W-1:0] g_pc;

    always #2.5 clk = ~clk;

    ras_predictor #(.DEPTH(D), .XLEN(W), .REG_W(5), .RA_IDX(1)) u0 (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .jmp_kind(jmp_kind),
        .rd_idx(rd_idx), .rs1_idx(rs1_idx), .pc(pc),
        .ret_hit(ret_hit), .pred_valid(pred_valid), .pred_pc(pred_pc)
    );

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        instr_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_ptr = 0;
        m_cnt = 0;
    endtask

    task automatic issue(input bit v, input logic [1:0] k, input logic [4:0] rd,
                         input logic [4:0] rs, input logic [W-1:0] p);
        bit push, pop, e_pv;
        logic [W-1:0] e_pc;
        int ti;
        string tag;
        @(negedge clk);
        instr_valid = v; jmp_kind = k; rd_idx = rd; rs1_idx = rs; pc = p;
        #1;
        push = v && (k == 2'b01 || k == 2'b10) && rd == 5'd1;
        pop  = v && k == 2'b10 && rs == 5'd1;
        ti   = (m_ptr + D - 1) % D;
        e_pv = pop && m_cnt > 0;
        e_pc = e_pv ? m_slot[ti] : '0;
        if (pop && push) tag = "R5";
        else if (pop && m_cnt == 0) tag = "R3";
        else if (pop) tag = "R2";
        else if (push) tag = "R1";
        else tag = "R6";
        g_rh = ret_hit; g_pv = pred_valid; g_pc = pred_pc;
        chk(ret_hit == pop, tag, W'(ret_hit), W'(pop));
        chk(pred_valid == e_pv, tag, W'(pred_valid), W'(e_pv));
        chk(pred_pc == e_pc, (e_pv ? tag : "R8"), pred_pc, e_pc);
        if (pop && push && m_cnt > 0) begin
            m_slot[ti] = W'(p + 4);
        end else begin
            if (pop && m_cnt > 0) begin m_ptr = ti; m_cnt--; end
            if (push) begin
                m_slot[m_ptr] = W'(p + 4);
                m_ptr = (m_ptr + 1) % D;
                if (m_cnt < D) m_cnt++;
            end
        end
    endtask

    task automatic call(input logic [W-1:0] p);
        issue(1, 2'b01, 5'd1, 5'd0, p);
    endtask

    task automatic ret(input bit e_pv, input logic [W-1:0] e_pc, input string tag);
        issue(1, 2'b10, 5'd0, 5'd1, 16'h0300);
        chk(g_rh == 1'b1, tag, W'(g_rh), 16'd1);
        chk(g_pv == e_pv, tag, W'(g_pv), W'(e_pv));
        chk(g_pc == e_pc, tag, g_pc, e_pc);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R7: stack empty right after reset
        ret(0, 16'h0000, "R7");

        // R1 and R2: last in first out
        call(16'h1000);
        call(16'h2000);
        ret(1, 16'h2004, "R2");
        ret(1, 16'h1004, "R1");
        ret(0, 16'h0000, "R3");
        ret(0, 16'h0000, "R3");

        // R4: six calls into four entries
        for (int i = 0; i < 6; i++) call(W'(16'h4000 + 16'h0100 * i));
        for (int i = 5; i >= 2; i--) ret(1, W'(16'h4004 + 16'h0100 * i), "R4");
        ret(0, 16'h0000, "R4");

        // R5: combined pop and push
        call(16'h5000);
        issue(1, 2'b10, 5'd1, 5'd1, 16'h5500);
        chk(g_pv && g_pc == 16'h5004, "R5", g_pc, 16'h5004);
        ret(1, 16'h5504, "R5");
        ret(0, 16'h0000, "R5");
        issue(1, 2'b10, 5'd1, 5'd1, 16'h5600);
        chk(!g_pv, "R5", W'(g_pv), 16'd0);
        ret(1, 16'h5604, "R5");

        // R6: ignored encodings leave the stack alone
        call(16'h6000);
        issue(1, 2'b01, 5'd0, 5'd0, 16'h6100);
        issue(1, 2'b10, 5'd5, 5'd0, 16'h6200);
        issue(1, 2'b01, 5'd0, 5'd1, 16'h6300);
        issue(1, 2'b11, 5'd1, 5'd1, 16'h6400);
        issue(1, 2'b00, 5'd1, 5'd1, 16'h6500);
        issue(0, 2'b10, 5'd1, 5'd1, 16'h6600);
        chk(!g_rh, "R6", W'(g_rh), 16'd0);
        ret(1, 16'h6004, "R6");
        ret(0, 16'h0000, "R6");

        // R7: reset while holding entries
        call(16'h7000);
        call(16'h7100);
        do_reset();
        ret(0, 16'h0000, "R7");

        // sweep of every rd, rs1 and kind against the model
        for (int k = 0; k < 4; k++)
            for (int rd = 0; rd < 32; rd++)
                for (int rs = 0; rs < 32; rs++)
                    issue(1, 2'(k), 5'(rd), 5'(rs), W'((k * 1024 + rd * 32 + rs) * 4));
        for (int i = 0; i < D + 1; i++) issue(1, 2'b10, 5'd0, 5'd1, 16'h0800);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule